// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches for software that has stopped running properly. A 12-bit counter counts down at a rate set by a selectable power-of-two prescaler. Software must reload it before it runs out. Software may not reload it too early either: a reload is only welcome once the count has dropped below a programmed window threshold. Either failure is a fault. Depending on the configured action, a fault sets a sticky interrupt flag or emits a fixed-length reset pulse.

Software reaches the block through a simple write port. Each write carries a 3-bit register select and a 16-bit data word. A reload counts only when the data carries a fixed reload key. The reload value, the window threshold and the configuration change only after an unlock key has been written to the lock register. While the debug-halt input is high, the counter and the prescaler hold their values.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `irqOut` and `rstOut` are low, counting is disabled and the configuration registers are locked. The reload value and the threshold both start at 0xFFF.
- R2: Select 3 is the configuration register: bits [2:0] hold the prescale exponent p, bit 3 picks the action (0 interrupt, 1 reset) and bit 4 enables counting. While counting is enabled, the counter steps down once every 2^p clocks. With no reload, the fault fires on the (N+1)·2^p-th clock edge after the counter was loaded with N and started.
- R3: A write to select 0 is a reload only when its data equals 0x5FA0. A reload loads the counter from the reload value (select 1, bits [11:0]) and clears the prescaler. A write to select 0 with any other data is ignored.
- R4: A reload accepted while the counter is greater than or equal to the threshold (select 2, bits [11:0]) is a fault. This includes the case where the counter equals the threshold.
- R5: A reload accepted while the counter is below the threshold raises no fault. This also holds on the clock edge where the counter would underflow from zero.
- R6: In interrupt action, a fault sets `irqOut`. The flag stays set until a write to select 5 with bit 0 equal to 1. A fault in the same cycle as that write keeps the flag set.
- R7: In reset action, a fault drives `rstOut` high for exactly 4 clocks and leaves `irqOut` unchanged.
- R8: Writing 0xCA35 to select 4 unlocks selects 1, 2 and 3; writing any other value to select 4 locks them again. While locked, writes to selects 1 to 3 are ignored.
- R9: While `dbgHalt` is high, the prescaler and the counter hold their values, so a pending underflow is delayed by the number of halted cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 16 | Write data |
| dbgHalt | input | 1 | Freezes counting while high |
| irqOut | output | 1 | Sticky interrupt flag |
| rstOut | output | 1 | Reset pulse |

## Verification
A valid reload and an underflow tick can land on the same clock edge. The bench forces this by arming the counter and waiting until the count reaches zero. It then issues the reload on exactly the edge where the underflow tick fires. The reload must win: no fault may appear, and the next fault must come a full period later. The boundary where the counter equals the threshold is tested on its own, and it must fault.

// File: rtl/win_wdt_pkg.sv
package win_wdt_pkg;
  typedef enum logic [2:0] {
    SEL_KICK   = 3'd0,
    SEL_RELOAD = 3'd1,
    SEL_DELTA  = 3'd2,
    SEL_CFG    = 3'd3,
    SEL_LOCK   = 3'd4,
    SEL_CLR    = 3'd5
  } regSel_e;

  typedef struct packed {
    logic load;  // reload counter, clear prescaler
    logic run;   // advance prescaler/counter
  } wdtStrobe_t;
endpackage

// File: rtl/win_wdt_dp.sv
module win_wdt_dp
  import win_wdt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobe_t        stb,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic [PSEL_W-1:0] preSel,
  output logic [CNT_W-1:0]  cntVal,
  output logic              tick
);
  localparam int PRE_W = (1 << PSEL_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;

  assign preMask = (PRE_W'(1) << preSel) - PRE_W'(1);
  assign tick    = stb.run && ((preCnt & preMask) == preMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      cntVal <= '1;
    end else if (stb.load) begin
      preCnt <= '0;
      cntVal <= reloadVal;
    end else if (stb.run) begin
      preCnt <= preCnt + PRE_W'(1);
      if (tick) cntVal <= cntVal - CNT_W'(1);
    end
  end
endmodule

// File: rtl/win_wdt_ctrl.sv
module win_wdt_ctrl
  import win_wdt_pkg::*;
#(
  parameter int              CNT_W      = 12,
  parameter int              PSEL_W     = 3,
  parameter int              KEY_W      = 16,
  parameter logic [KEY_W-1:0] KICK_KEY   = 16'h5FA0,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hCA35,
  parameter int              RST_PULSE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [KEY_W-1:0]  wrData,
  input  logic              dbgHalt,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cntVal,
  output wdtStrobe_t        stb,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [PSEL_W-1:0] preSel,
  output logic              kickOk,
  output logic              faultEvt,
  output logic              irqOut,
  output logic              rstOut
);
  localparam int RST_CW = $clog2(RST_PULSE + 1);

  logic [CNT_W-1:0]  deltaVal;
  logic              cfgEn;
  logic              cfgRstMode;
  logic              unlocked;
  logic [RST_CW-1:0] rstCnt;
  logic              earlyFault;
  logic              underFault;
  logic              cfgWr;
  logic              clrWr;

  assign kickOk     = wrEn && (wrAddr == SEL_KICK) && (wrData == KICK_KEY);
  assign earlyFault = kickOk && (cntVal >= deltaVal);
  assign underFault = tick && (cntVal == '0) && !kickOk;
  assign faultEvt   = earlyFault || underFault;
  assign cfgWr      = wrEn && unlocked;
  assign clrWr      = wrEn && (wrAddr == SEL_CLR) && wrData[0];

  assign stb.load = kickOk || underFault;
  assign stb.run  = cfgEn && !dbgHalt;

  // configuration and lock registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal  <= '1;
      deltaVal   <= '1;
      preSel     <= '0;
      cfgEn      <= 1'b0;
      cfgRstMode <= 1'b0;
      unlocked   <= 1'b0;
    end else begin
      if (wrEn && (wrAddr == SEL_LOCK)) unlocked <= (wrData == UNLOCK_KEY);
      if (cfgWr && (wrAddr == SEL_RELOAD)) reloadVal <= wrData[CNT_W-1:0];
      if (cfgWr && (wrAddr == SEL_DELTA))  deltaVal  <= wrData[CNT_W-1:0];
      if (cfgWr && (wrAddr == SEL_CFG)) begin
        preSel     <= wrData[PSEL_W-1:0];
        cfgRstMode <= wrData[PSEL_W];
        cfgEn      <= wrData[PSEL_W+1];
      end
    end
  end

  // fault actions
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      rstCnt <= '0;
    end else begin
      if (faultEvt && !cfgRstMode) irqOut <= 1'b1;
      else if (clrWr)              irqOut <= 1'b0;

      if (faultEvt && cfgRstMode)  rstCnt <= RST_CW'(RST_PULSE);
      else if (rstCnt != '0)       rstCnt <= rstCnt - RST_CW'(1);
    end
  end

  assign rstOut = (rstCnt != '0);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import win_wdt_pkg::*;
#(
  parameter int              CNT_W      = 12,
  parameter int              PSEL_W     = 3,
  parameter int              KEY_W      = 16,
  parameter logic [KEY_W-1:0] KICK_KEY   = 16'h5FA0,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hCA35,
  parameter int              RST_PULSE  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [KEY_W-1:0] wrData,
  input  logic             dbgHalt,
  output logic             irqOut,
  output logic             rstOut
);
  wdtStrobe_t        stb;
  logic [CNT_W-1:0]  reloadVal;
  logic [PSEL_W-1:0] preSel;
  logic [CNT_W-1:0]  cntVal;
  logic              tick;
  logic              kickOk;
  logic              faultEvt;

  win_wdt_ctrl #(
    .CNT_W(CNT_W), .PSEL_W(PSEL_W), .KEY_W(KEY_W),
    .KICK_KEY(KICK_KEY), .UNLOCK_KEY(UNLOCK_KEY), .RST_PULSE(RST_PULSE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgHalt(dbgHalt), .tick(tick), .cntVal(cntVal), .stb(stb),
    .reloadVal(reloadVal), .preSel(preSel), .kickOk(kickOk),
    .faultEvt(faultEvt), .irqOut(irqOut), .rstOut(rstOut)
  );

  win_wdt_dp #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reloadVal(reloadVal),
    .preSel(preSel), .cntVal(cntVal), .tick(tick)
  );
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
  parameter int CNT_W     = 12,
  parameter int KEY_W     = 16,
  parameter int RST_PULSE = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [KEY_W-1:0] wrData,
  input logic             dbgHalt,
  input logic             irqOut,
  input logic             rstOut,
  input logic [CNT_W-1:0] cntVal,
  input logic             kickOk,
  input logic             faultEvt
);
  logic clrWr;
  logic [7:0] rstRun;
  assign clrWr = wrEn && (wrAddr == 3'd5) && wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN)       rstRun <= '0;
    else if (rstOut) rstRun <= (rstRun == 8'hFF) ? rstRun : rstRun + 8'd1;
    else             rstRun <= '0;
  end

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dbgHalt && !kickOk) |=> $stable(cntVal));

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !clrWr) |=> irqOut);

  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !faultEvt) |=> !irqOut);

  assert_fault_acts_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultEvt |=> (irqOut || rstOut));

  assert_rst_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstRun <= 8'(RST_PULSE));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!kickOk && !faultEvt) |=> (cntVal == $past(cntVal)) || (cntVal == $past(cntVal) - CNT_W'(1)));
endmodule

bind win_watchdog win_watchdog_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W), .RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .dbgHalt(dbgHalt), .irqOut(irqOut), .rstOut(rstOut), .cntVal(cntVal),
  .kickOk(kickOk), .faultEvt(faultEvt)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  localparam logic [15:0] KICK   = 16'h5FA0;
  localparam logic [15:0] UNLOCK = 16'hCA35;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        dbgHalt = 1'b0;
  logic        irqOut, rstOut;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  win_watchdog u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgHalt(dbgHalt), .irqOut(irqOut), .rstOut(rstOut)
  );

  task automatic chk(string tag, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(logic [2:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // stop, load counter, clear flag, start; counter starts stepping on next edge
  task automatic arm(logic [2:0] p, logic rstMode);
    wr(3'd3, 16'h0000);
    wr(3'd0, KICK);
    wr(3'd5, 16'h0001);
    wr(3'd3, {11'd0, 1'b1, rstMode, p});
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", irqOut, 1'b0);
    chk("R1 rst after reset", rstOut, 1'b0);
    idle(10);
    chk("R1 disabled: no fault", irqOut, 1'b0);
  endtask

  task automatic t_setup;
    wr(3'd4, UNLOCK);
    wr(3'd1, 16'd5);
    wr(3'd2, 16'd3);
  endtask

  task automatic t_timing_p0;
    arm(3'd0, 1'b0);
    idle(5);
    chk("R2 p=0 before underflow", irqOut, 1'b0);
    idle(1);
    chk("R2 p=0 at underflow", irqOut, 1'b1);
  endtask

  task automatic t_timing_p1;
    arm(3'd1, 1'b0);
    idle(11);
    chk("R2 p=1 before underflow", irqOut, 1'b0);
    idle(1);
    chk("R2 p=1 at underflow", irqOut, 1'b1);
  endtask

  task automatic t_clear;
    arm(3'd0, 1'b0);
    idle(6);
    idle(2);
    chk("R6 flag sticky", irqOut, 1'b1);
    wr(3'd5, 16'h0001);
    chk("R6 flag cleared", irqOut, 1'b0);
  endtask

  task automatic t_bad_key;
    arm(3'd0, 1'b0);
    wr(3'd0, 16'h5FA1);
    chk("R3 bad key no early fault", irqOut, 1'b0);
    idle(4);
    chk("R3 bad key no reload before", irqOut, 1'b0);
    idle(1);
    chk("R3 bad key underflow on time", irqOut, 1'b1);
  endtask

  task automatic t_early;
    arm(3'd0, 1'b0);
    wr(3'd0, KICK);
    chk("R4 reload far above threshold", irqOut, 1'b1);
    arm(3'd0, 1'b0);
    idle(2);
    wr(3'd0, KICK);
    chk("R4 reload at threshold", irqOut, 1'b1);
  endtask

  task automatic t_window;
    arm(3'd0, 1'b0);
    idle(3);
    wr(3'd0, KICK);
    chk("R5 reload below threshold", irqOut, 1'b0);
    idle(5);
    chk("R5 reloaded period before", irqOut, 1'b0);
    idle(1);
    chk("R5 reloaded period end", irqOut, 1'b1);
  endtask

  task automatic t_coincide;
    arm(3'd0, 1'b0);
    idle(5);
    wr(3'd0, KICK);
    chk("R5 reload on underflow edge", irqOut, 1'b0);
    idle(5);
    chk("R5 after coincident reload", irqOut, 1'b0);
    idle(1);
    chk("R5 next underflow", irqOut, 1'b1);
  endtask

  task automatic t_rst_mode;
    arm(3'd0, 1'b1);
    idle(5);
    chk("R7 no pulse before fault", rstOut, 1'b0);
    idle(1);
    chk("R7 pulse start", rstOut, 1'b1);
    chk("R7 irq untouched", irqOut, 1'b0);
    idle(3);
    chk("R7 pulse 4th clock", rstOut, 1'b1);
    idle(1);
    chk("R7 pulse end", rstOut, 1'b0);
  endtask

  task automatic t_lock;
    arm(3'd0, 1'b0);
    wr(3'd4, 16'h0000);
    wr(3'd3, 16'h0018);
    wr(3'd0, KICK);
    chk("R8 locked cfg keeps irq action", irqOut, 1'b1);
    chk("R8 locked cfg no reset", rstOut, 1'b0);
    wr(3'd4, UNLOCK);
  endtask

  task automatic t_halt;
    arm(3'd0, 1'b0);
    dbgHalt = 1'b1;
    idle(10);
    chk("R9 no fault during halt", irqOut, 1'b0);
    dbgHalt = 1'b0;
    idle(5);
    chk("R9 delayed before", irqOut, 1'b0);
    idle(1);
    chk("R9 delayed underflow", irqOut, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_timing_p0;
    t_timing_p1;
    t_clear;
    t_bad_key;
    t_early;
    t_window;
    t_coincide;
    t_rst_mode;
    t_lock;
    t_halt;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run;
  end
endmodule